// File: doc/BRIEF.md
# Flow-Controlled Serial Port

A full-duplex asynchronous serial port with a character queue in each direction and an optional pair of active-low handshake lines. A host reaches it through a four-word register window: a data word (write to queue a character for sending, read to take a received one), a status word and a control word. Characters use the 8N1 frame: one low start bit, eight data bits least significant first, one high stop bit. The bit period is 16 times a parameterised oversampling divisor, and the receiver takes each bit at its middle.

When the handshake build option is on, the transmitter moves a character from its queue into the shift register only while the partner holds `cts_n` low. A character already in the shift register always runs to its stop bit. The `rts_n` output follows a software request bit, and the receiver overrides it and holds it high while its queue has too few free slots. When the option is off, `cts_n` is ignored, `rts_n` stays high, and queued characters leave back to back.

Top module: `fc_uart`

## Requirements
- R1: After reset `txd` and `rts_n` are high, the control word reads 0x00 and the status word reads 0x04 while `cts_n` is high.
- R2: Each transmitted character is a low start bit, eight data bits LSB first and a high stop bit, each bit lasting 16*OVS_DIV clocks. `txd` is high when idle.
- R3: A frame on `rxd` is sampled at mid-bit and its byte stored. Status bit 0 is 1 while a received byte waits, and a read of address 0 returns the oldest byte and removes it.
- R4: A write to address 0 queues a byte for sending. Status bit 1 is 1 while the send queue is full, and a write to a full queue is discarded.
- R5: With HS_EN=1, a character enters the shift register only while the synchronised `cts_n` is low. Status bit 4 reads 1 while `cts_n` is low.
- R6: If `cts_n` rises during a character, that character still completes, and the next one starts only after `cts_n` is low again.
- R7: Status bit 2 is 1 only when the send queue is empty and the last stop bit has ended.
- R8: Control bit 0 at address 3 is readable. With HS_EN=1 and the receive queue not nearly full, `rts_n` is low exactly while this bit is 1.
- R9: With HS_EN=1, while the receive queue holds RX_DEPTH-AF_SPACE bytes or more, status bit 3 is 1 and `rts_n` is high. `rts_n` goes low again once a read brings the count below that level.
- R10: A byte that completes while the receive queue is full is dropped and sets status bit 5. Bit 5 stays set until a read of address 2 clears it.
- R11: With HS_EN=0, `cts_n` has no effect, `rts_n` stays high, and queued characters are sent back to back.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| addr | input | 2 | Register word address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops data, clears overrun) |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr`, combinational |
| txd | output | 1 | Serial transmit line |
| rxd | input | 1 | Serial receive line |
| cts_n | input | 1 | Partner permits sending, active low |
| rts_n | output | 1 | Ready to receive, active low |

## Verification
The assertions take as given that `rxd` carries whole frames whose bit timing is close to 16*OVS_DIV clocks, and that `rd_en` and `wr_en` last one cycle each. The bench builds each frame bit by bit from the same parameter, holding every level for exactly one bit period. It drives every strobe for a single clock, with address and data changed only on the falling edge. `cts_n` changes only on the falling edge and is never sampled directly by the logic: a two-stage synchroniser comes first, so the gating properties work on a level that is stable within a cycle.

// File: rtl/fcu_pkg.sv
package fcu_pkg;
   localparam logic [1:0] ADDR_DATA = 2'd0;
   localparam logic [1:0] ADDR_STAT = 2'd2;
   localparam logic [1:0] ADDR_CTRL = 2'd3;

   localparam int ST_RXAV = 0;
   localparam int ST_TXFULL = 1;
   localparam int ST_TXIDLE = 2;
   localparam int ST_RXAF = 3;
   localparam int ST_CTS = 4;
   localparam int ST_OVR = 5;

   typedef enum logic [1:0] {RX_IDLE, RX_START, RX_DATA, RX_STOP} rx_state_t;
endpackage

// File: rtl/fcu_fifo.sv
module fcu_fifo #(
   parameter int W = 8,
   parameter int DEPTH = 8
) (
   input  logic                       clk,
   input  logic                       rst_n,
   input  logic                       push,
   input  logic [W-1:0]               din,
   input  logic                       pop,
   output logic [W-1:0]               dout,
   output logic                       full,
   output logic                       empty,
   output logic [$clog2(DEPTH+1)-1:0] count
);
   localparam int AW = $clog2(DEPTH);
   localparam int CW = $clog2(DEPTH+1);

   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("fcu_fifo: DEPTH must be a power of two, at least 2");
      end
   endgenerate

   logic [W-1:0]  mem [DEPTH];
   logic [AW-1:0] wptr, rptr;
   logic          push_ok, pop_ok;

   assign full    = (count == CW'(DEPTH));
   assign empty   = (count == '0);
   assign push_ok = push && !full;
   assign pop_ok  = pop && !empty;
   assign dout    = mem[rptr];

   always_ff @(posedge clk) begin
      if (push_ok) mem[wptr] <= din;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr  <= '0;
         rptr  <= '0;
         count <= '0;
      end else begin
         if (push_ok) wptr <= wptr + 1'b1;
         if (pop_ok) rptr <= rptr + 1'b1;
         count <= count + CW'(push_ok) - CW'(pop_ok);
      end
   end

   a_r4_full_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (full && push && !pop) |=> (full && $stable(wptr)));
   a_r10_count_bound: assert property (@(posedge clk) disable iff (!rst_n)
      count <= CW'(DEPTH));
endmodule

// File: rtl/fcu_tx.sv
module fcu_tx #(
   parameter int OVS_DIV = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       load,
   input  logic [7:0] din,
   output logic       txd,
   output logic       busy
);
   localparam int BIT_CLKS = 16 * OVS_DIV;
   localparam int CW = $clog2(BIT_CLKS + 1);

   logic [9:0]    sh;
   logic [3:0]    nbit;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         sh   <= '1;
         nbit <= '0;
         cnt  <= '0;
         busy <= 1'b0;
      end else if (load) begin
         sh   <= {1'b1, din, 1'b0};
         nbit <= '0;
         cnt  <= '0;
         busy <= 1'b1;
      end else if (busy) begin
         if (cnt == CW'(BIT_CLKS - 1)) begin
            cnt <= '0;
            sh  <= {1'b1, sh[9:1]};
            if (nbit == 4'd9) busy <= 1'b0;
            else nbit <= nbit + 1'b1;
         end else begin
            cnt <= cnt + 1'b1;
         end
      end
   end

   assign txd = busy ? sh[0] : 1'b1;

   a_r6_load_only_idle: assert property (@(posedge clk) disable iff (!rst_n)
      load |-> !busy);
   a_r2_start_low: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(busy) |-> !txd);
   a_r2_bit_hold: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && cnt != '0) |-> $stable(txd));
endmodule

// File: rtl/fcu_rx.sv
module fcu_rx
   import fcu_pkg::*;
#(
   parameter int OVS_DIV = 2
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       rxd,
   output logic       valid,
   output logic [7:0] data
);
   localparam int OCW = $clog2(OVS_DIV + 1);

   rx_state_t      state;
   logic [OCW-1:0] oc;
   logic [3:0]     sub;
   logic [2:0]     nbit;
   logic           tick;

   assign tick = (oc == OCW'(OVS_DIV - 1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= RX_IDLE;
         oc    <= '0;
         sub   <= '0;
         nbit  <= '0;
         data  <= '0;
         valid <= 1'b0;
      end else begin
         valid <= 1'b0;
         if (state == RX_IDLE) begin
            oc  <= '0;
            sub <= '0;
            if (!rxd) state <= RX_START;
         end else begin
            oc <= tick ? '0 : oc + 1'b1;
            if (tick) begin
               sub <= sub + 1'b1;
               unique case (state)
                  RX_START: if (sub == 4'd7) begin
                     sub   <= '0;
                     nbit  <= '0;
                     state <= rxd ? RX_IDLE : RX_DATA;
                  end
                  RX_DATA: if (sub == 4'd15) begin
                     data <= {rxd, data[7:1]};
                     nbit <= nbit + 1'b1;
                     if (nbit == 3'd7) state <= RX_STOP;
                  end
                  RX_STOP: if (sub == 4'd15) begin
                     valid <= rxd;
                     state <= RX_IDLE;
                  end
                  default: state <= RX_IDLE;
               endcase
            end
         end
      end
   end

   a_r3_valid_single: assert property (@(posedge clk) disable iff (!rst_n)
      valid |=> !valid);
   a_r3_valid_after_stop: assert property (@(posedge clk) disable iff (!rst_n)
      valid |-> (state == RX_IDLE && $past(state) == RX_STOP));
endmodule

// File: rtl/fc_uart.sv
module fc_uart
   import fcu_pkg::*;
#(
   parameter int OVS_DIV  = 2,
   parameter int TX_DEPTH = 8,
   parameter int RX_DEPTH = 8,
   parameter int AF_SPACE = 2,
   parameter bit HS_EN    = 1'b1
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [1:0] addr,
   input  logic       wr_en,
   input  logic       rd_en,
   input  logic [7:0] wdata,
   output logic [7:0] rdata,
   output logic       txd,
   input  logic       rxd,
   input  logic       cts_n,
   output logic       rts_n
);
   localparam int TCW = $clog2(TX_DEPTH + 1);
   localparam int RCW = $clog2(RX_DEPTH + 1);
   localparam int AF_LEVEL = RX_DEPTH - AF_SPACE;

   generate
      if (OVS_DIV < 1) begin : g_bad_div
         $error("fc_uart: OVS_DIV must be at least 1");
      end
      if (AF_SPACE < 1 || AF_SPACE >= RX_DEPTH) begin : g_bad_af
         $error("fc_uart: AF_SPACE must lie in 1..RX_DEPTH-1");
      end
   endgenerate

   logic [1:0] rxd_s, cts_s;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rxd_s <= 2'b11;
         cts_s <= 2'b11;
      end else begin
         rxd_s <= {rxd_s[0], rxd};
         cts_s <= {cts_s[0], cts_n};
      end
   end

   logic           tx_full, tx_empty, tx_busy, tx_load, cts_ok;
   logic [7:0]     tx_byte, rx_byte, rx_head;
   logic [TCW-1:0] tx_count;
   logic           rx_full, rx_empty, rx_valid, rx_af;
   logic [RCW-1:0] rx_count;
   logic           rts_req, ovr, data_wr, data_rd, stat_rd;

   assign data_wr = wr_en && addr == ADDR_DATA;
   assign data_rd = rd_en && addr == ADDR_DATA;
   assign stat_rd = rd_en && addr == ADDR_STAT;

   generate
      if (HS_EN) begin : g_hs
         assign cts_ok = !cts_s[1];
         assign rts_n  = !(rts_req && !rx_af);
      end else begin : g_no_hs
         assign cts_ok = 1'b1;
         assign rts_n  = 1'b1;
      end
   endgenerate

   assign tx_load = !tx_empty && !tx_busy && cts_ok;
   assign rx_af   = rx_count >= RCW'(AF_LEVEL);

   fcu_fifo #(.W(8), .DEPTH(TX_DEPTH)) u_txq (
      .clk(clk), .rst_n(rst_n), .push(data_wr), .din(wdata), .pop(tx_load),
      .dout(tx_byte), .full(tx_full), .empty(tx_empty), .count(tx_count));

   fcu_tx #(.OVS_DIV(OVS_DIV)) u_ser (
      .clk(clk), .rst_n(rst_n), .load(tx_load), .din(tx_byte),
      .txd(txd), .busy(tx_busy));

   fcu_rx #(.OVS_DIV(OVS_DIV)) u_des (
      .clk(clk), .rst_n(rst_n), .rxd(rxd_s[1]), .valid(rx_valid), .data(rx_byte));

   fcu_fifo #(.W(8), .DEPTH(RX_DEPTH)) u_rxq (
      .clk(clk), .rst_n(rst_n), .push(rx_valid), .din(rx_byte), .pop(data_rd),
      .dout(rx_head), .full(rx_full), .empty(rx_empty), .count(rx_count));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         rts_req <= 1'b0;
         ovr     <= 1'b0;
      end else begin
         if (wr_en && addr == ADDR_CTRL) rts_req <= wdata[0];
         if (rx_valid && rx_full) ovr <= 1'b1;
         else if (stat_rd) ovr <= 1'b0;
      end
   end

   always_comb begin
      rdata = '0;
      unique case (addr)
         ADDR_DATA: rdata = rx_head;
         ADDR_STAT: begin
            rdata[ST_RXAV]   = !rx_empty;
            rdata[ST_TXFULL] = tx_full;
            rdata[ST_TXIDLE] = tx_empty && !tx_busy;
            rdata[ST_RXAF]   = rx_af;
            rdata[ST_CTS]    = HS_EN && !cts_s[1];
            rdata[ST_OVR]    = ovr;
         end
         ADDR_CTRL: rdata[0] = rts_req;
         default: rdata = '0;
      endcase
   end

   a_r5_cts_gate: assert property (@(posedge clk) disable iff (!rst_n)
      (HS_EN && $rose(tx_busy)) |-> !$past(cts_s[1]));
   a_r9_throttle: assert property (@(posedge clk) disable iff (!rst_n)
      (HS_EN && rx_count >= RCW'(AF_LEVEL)) |-> rts_n);
   a_r10_overrun_set: assert property (@(posedge clk) disable iff (!rst_n)
      (rx_valid && rx_full) |=> (ovr && $stable(rx_count)));
   a_r4_tx_bound: assert property (@(posedge clk) disable iff (!rst_n)
      tx_count <= TCW'(TX_DEPTH));
   a_r11_no_hs_rts: assert property (@(posedge clk) disable iff (!rst_n)
      !HS_EN |-> rts_n);
endmodule

// File: tb/fc_uart_test.sv
module fc_uart_test;
   localparam int OVS = 2;
   localparam int BITC = 16 * OVS;
   localparam logic [15:0] VEC [4] = '{16'h55_3C, 16'hA3_81, 16'h00_FF, 16'hFF_00};

   logic clk = 1'b0, rst_n = 1'b0;
   logic [1:0] addr = '0;
   logic wr_en = 1'b0, rd_en = 1'b0, wr_nh = 1'b0;
   logic [7:0] wdata = '0;
   logic [7:0] rdata, rdata_nh;
   logic txd, txd_nh, rts_n, rts_n_nh;
   logic rxd = 1'b1, cts_n = 1'b1, mon_sel = 1'b0;
   logic mon;
   int checks = 0, fails = 0;

   always #10 clk = ~clk;
   assign mon = mon_sel ? txd_nh : txd;

   fc_uart #(.OVS_DIV(OVS), .HS_EN(1'b1)) uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
      .wdata(wdata), .rdata(rdata), .txd(txd), .rxd(rxd), .cts_n(cts_n), .rts_n(rts_n));

   fc_uart #(.OVS_DIV(OVS), .HS_EN(1'b0)) uut_nh (
      .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_nh), .rd_en(1'b0),
      .wdata(wdata), .rdata(rdata_nh), .txd(txd_nh), .rxd(1'b1), .cts_n(1'b1),
      .rts_n(rts_n_nh));

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [1:0] a, input logic [7:0] d, input bit nh);
      @(negedge clk);
      addr = a; wdata = d;
      if (nh) wr_nh = 1'b1; else wr_en = 1'b1;
      @(negedge clk);
      wr_en = 1'b0; wr_nh = 1'b0;
   endtask

   task automatic rd(input logic [1:0] a, output logic [7:0] d);
      @(negedge clk);
      addr = a; rd_en = 1'b1;
      #2 d = rdata;
      @(negedge clk);
      rd_en = 1'b0;
   endtask

   task automatic send(input logic [7:0] b);
      @(negedge clk);
      rxd = 1'b0;
      repeat (BITC) @(negedge clk);
      for (int i = 0; i < 8; i++) begin
         rxd = b[i];
         repeat (BITC) @(negedge clk);
      end
      rxd = 1'b1;
      repeat (BITC + 4) @(negedge clk);
   endtask

   // Returns mid-stop-bit; found=0 if no start bit within tmax cycles.
   task automatic cap(input int tmax, input bit drop, output logic [7:0] b,
                      output bit found, output logic stopb);
      int t = 0;
      b = '0; found = 1'b0; stopb = 1'b0;
      @(negedge clk);
      while (mon !== 1'b0 && t < tmax) begin
         @(negedge clk);
         t++;
      end
      if (mon === 1'b0) begin
         found = 1'b1;
         repeat (BITC / 2) @(negedge clk);
         for (int i = 0; i < 8; i++) begin
            repeat (BITC) @(negedge clk);
            b[i] = mon;
            if (drop && i == 2) cts_n = 1'b1;
         end
         repeat (BITC) @(negedge clk);
         stopb = mon;
      end
   endtask

   task automatic quiet(input int n, input string req);
      bit low = 1'b0;
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         if (mon !== 1'b1) low = 1'b1;
      end
      chk(!low, req, low, 0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      fails++;
      checks++;
      $display("FAIL watchdog expired actual=timeout expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end

   initial begin
      logic [7:0] d, b;
      bit found;
      logic sb;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk(txd === 1'b1 && rts_n === 1'b1, "R1 lines", {txd, rts_n}, 2'b11);
      rd(2'd2, d); chk(d === 8'h04, "R1 status", d, 8'h04);
      rd(2'd3, d); chk(d === 8'h00, "R1 control", d, 8'h00);

      // R8 software request drives rts_n; R5 cts status bit 4
      wr(2'd3, 8'h01, 1'b0);
      rd(2'd3, d); chk(d === 8'h01, "R8 control readback", d, 8'h01);
      chk(rts_n === 1'b0, "R8 rts_n low", rts_n, 0);
      cts_n = 1'b0;
      repeat (3) @(negedge clk);
      rd(2'd2, d); chk(d[4] === 1'b1, "R5 cts status", d[4], 1);

      // R2/R3 vector table: transmit upper byte, receive lower byte
      for (int v = 0; v < 4; v++) begin
         wr(2'd0, VEC[v][15:8], 1'b0);
         rd(2'd2, d); chk(d[2] === 1'b0, "R7 busy while sending", d[2], 0);
         cap(200, 1'b0, b, found, sb);
         chk(found && b === VEC[v][15:8] && sb === 1'b1, "R2 tx frame", b, VEC[v][15:8]);
         rd(2'd2, d); chk(d[2] === 1'b0, "R7 not empty during stop bit", d[2], 0);
         repeat (BITC) @(negedge clk);
         rd(2'd2, d); chk(d[2] === 1'b1, "R7 empty after stop", d[2], 1);
         send(VEC[v][7:0]);
         rd(2'd2, d); chk(d[0] === 1'b1, "R3 byte available", d[0], 1);
         rd(2'd0, d); chk(d === VEC[v][7:0], "R3 rx byte", d, VEC[v][7:0]);
         rd(2'd2, d); chk(d[0] === 1'b0, "R3 queue drained", d[0], 0);
      end

      // R5 no load while cts_n high
      cts_n = 1'b1;
      repeat (5) @(negedge clk);
      rd(2'd2, d); chk(d[4] === 1'b0, "R5 cts status low", d[4], 0);
      wr(2'd0, 8'h96, 1'b0);
      quiet(300, "R5 held by cts_n");
      rd(2'd2, d); chk(d[2] === 1'b0, "R7 queued not empty", d[2], 0);
      cts_n = 1'b0;
      cap(200, 1'b0, b, found, sb);
      chk(found && b === 8'h96, "R5 sent after cts", b, 8'h96);

      // R6 cts_n rises mid-character
      repeat (BITC) @(negedge clk);
      wr(2'd0, 8'hC5, 1'b0);
      wr(2'd0, 8'h2E, 1'b0);
      cap(200, 1'b1, b, found, sb);
      chk(found && b === 8'hC5 && sb === 1'b1, "R6 in-flight completes", b, 8'hC5);
      quiet(400, "R6 next held");
      cts_n = 1'b0;
      cap(200, 1'b0, b, found, sb);
      chk(found && b === 8'h2E, "R6 resumes", b, 8'h2E);
      repeat (BITC) @(negedge clk);

      // R9 receive throttle at RX_DEPTH-AF_SPACE = 6
      for (int i = 1; i <= 5; i++) send(8'(8'h10 + i));
      rd(2'd2, d); chk(d[3] === 1'b0 && rts_n === 1'b0, "R9 below level", {d[3], rts_n}, 0);
      send(8'h16);
      rd(2'd2, d); chk(d[3] === 1'b1 && rts_n === 1'b1, "R9 at level", {d[3], rts_n}, 3);
      rd(2'd0, d); chk(d === 8'h11, "R9 oldest", d, 8'h11);
      @(negedge clk);
      chk(rts_n === 1'b0, "R9 rts_n restored", rts_n, 0);

      // R10 overrun
      for (int i = 7; i <= 10; i++) send(8'(8'h10 + i));
      rd(2'd2, d); chk(d[5] === 1'b1, "R10 overrun set", d[5], 1);
      rd(2'd2, d); chk(d[5] === 1'b0, "R10 overrun cleared", d[5], 0);
      for (int i = 2; i <= 9; i++) begin
         rd(2'd0, d); chk(d === 8'(8'h10 + i), "R10 kept bytes", d, 8'h10 + i);
      end
      rd(2'd2, d); chk(d[0] === 1'b0, "R10 dropped byte absent", d[0], 0);

      // R4 full send queue discards the extra write
      cts_n = 1'b1;
      repeat (5) @(negedge clk);
      for (int i = 0; i < 8; i++) wr(2'd0, 8'(8'h40 + i), 1'b0);
      rd(2'd2, d); chk(d[1] === 1'b1, "R4 tx full", d[1], 1);
      wr(2'd0, 8'hEE, 1'b0);
      cts_n = 1'b0;
      for (int i = 0; i < 8; i++) begin
         cap(200, 1'b0, b, found, sb);
         chk(found && b === 8'(8'h40 + i), "R4 queued order", b, 8'h40 + i);
      end
      quiet(400, "R4 extra write discarded");
      rd(2'd2, d); chk(d[2] === 1'b1, "R7 idle at end", d[2], 1);

      // R8 clearing the request raises rts_n
      wr(2'd3, 8'h00, 1'b0);
      chk(rts_n === 1'b1, "R8 rts_n high", rts_n, 1);

      // R11 no handshake build
      mon_sel = 1'b1;
      wr(2'd0, 8'h5A, 1'b1);
      wr(2'd0, 8'hA5, 1'b1);
      cap(200, 1'b0, b, found, sb);
      chk(found && b === 8'h5A, "R11 sends with cts_n high", b, 8'h5A);
      cap(BITC, 1'b0, b, found, sb);
      chk(found && b === 8'hA5, "R11 back to back", b, 8'hA5);
      chk(rts_n_nh === 1'b1, "R11 rts_n constant", rts_n_nh, 1);

      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
   end
endmodule